// File: doc/BRIEF.md
# Four-Digit Millisecond Counter with Scanned Display

This block keeps a four-digit decimal count whose lowest digit steps once per millisecond, so the highest digit steps once per second. A prescaler turns the system clock into a one-cycle millisecond pulse. That pulse drives a chain of decade counters, where each digit carries into the one above it. The count advances only while the `run` input is high, and a start/stop controller outside the block drives that input.

All digits share one set of seven segment lines. A free-running scan generator lights one digit at a time. At each step it chooses the digit-select line and routes that digit's value through a seven-segment decoder. Both divider counts are parameters, so a simulation can use short values and silicon can use the real millisecond values.

Top module: `msec_scan_display`

## Requirements
- R1: An active-low asynchronous reset clears every digit, both prescalers and the scan position. During reset and right after it, `dig_sel_n` is 4'b1110 and the segment lines show the pattern for 0.
- R2: The count rises by one for every TICK_DIV rising clock edges at which `run` is high. The first step comes at the TICK_DIV-th such edge after reset.
- R3: While `run` is low, the count and the millisecond prescaler phase are frozen. When `run` returns high, counting continues from the held phase.
- R4: Each digit counts 0 to 9. A digit passing from 9 to 0 steps the next digit up in the same clock, and the full count wraps from 9999 to 0000.
- R5: The scan position moves every SCAN_DIV clock cycles in the order digit 0, 1, 2, 3, then back to 0, whether `run` is high or low.
- R6: `dig_sel_n` is active-low and one-hot. Bit k low selects digit k, and exactly one bit is low in every cycle.
- R7: `seg_lines` carries the decoded value of the selected digit, with bit 0 = segment a through bit 6 = segment g. With the default polarity a 0 bit lights a segment. The patterns are: 0 lights a–f; 1 lights b,c; 2 lights a,b,d,e,g; 3 lights a,b,c,d,g; 4 lights b,c,f,g; 5 lights a,c,d,f,g; 6 lights a,c–g; 7 lights a,b,c; 8 lights all; 9 lights a,b,c,d,f,g.
- R8: Digit 0 holds the units of milliseconds and digit 3 is the most significant, so the displayed value is d3·1000 + d2·100 + d1·10 + d0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Counting enable from the start/stop controller |
| seg_lines | output | 7 | Shared segment lines, bit 0 = a … bit 6 = g |
| dig_sel_n | output | 4 | Active-low one-hot digit select |

## Verification
The bound checker tests the following properties on every cycle:
- The digit selects are one-hot.
- The scan moves only by one rotation step.
- No digit ever holds a value above 9.
- The count is unchanged on any cycle without a millisecond pulse or with `run` low.
- The units digit steps by exactly one modulo ten on each pulse.

Some behaviours need the bench's scenarios:
- the exact spacing of counts and scan steps in cycles;
- the decimal carry and the 9999 wrap as seen on the display;
- holding the prescaler phase across a stop;
- segment patterns that match the selected digit;
- an asynchronous reset taking effect in the middle of a cycle.

// File: rtl/msd_pkg.sv
package msd_pkg;
   localparam int SEG_W = 7;
   typedef logic [3:0]       bcd_t;
   typedef logic [SEG_W-1:0] seg_t;

   // active-high pattern, bit 0 = a ... bit 6 = g; non-decimal codes blank
   function automatic seg_t seg_pattern(input bcd_t v);
      case (v)
         4'd0:    return 7'h3F;
         4'd1:    return 7'h06;
         4'd2:    return 7'h5B;
         4'd3:    return 7'h4F;
         4'd4:    return 7'h66;
         4'd5:    return 7'h6D;
         4'd6:    return 7'h7D;
         4'd7:    return 7'h07;
         4'd8:    return 7'h7F;
         4'd9:    return 7'h6F;
         default: return 7'h00;
      endcase
   endfunction
endpackage

// File: rtl/msd_tick_gen.sv
module msd_tick_gen #(
   parameter int DIV = 100000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);
   localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   if (DIV < 2) begin : g_bad_div
      $error("msd_tick_gen: DIV must be at least 2");
   end

   logic [CW-1:0] cnt;

   assign tick = en && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (en) begin
         cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      end
   end
endmodule

// File: rtl/msd_decade_chain.sv
module msd_decade_chain
   import msd_pkg::*;
#(
   parameter int NUM_DIGITS = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       step,
   output bcd_t [NUM_DIGITS-1:0]      digits
);
   logic [NUM_DIGITS:0] carry;

   assign carry[0] = step;

   for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_dig
      assign carry[i+1] = carry[i] && (digits[i] == 4'd9);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            digits[i] <= 4'd0;
         end else if (carry[i]) begin
            digits[i] <= (digits[i] == 4'd9) ? 4'd0 : digits[i] + 4'd1;
         end
      end
   end
endmodule

// File: rtl/msd_scan_mux.sv
module msd_scan_mux
   import msd_pkg::*;
#(
   parameter int NUM_DIGITS     = 4,
   parameter bit SEG_ACTIVE_LOW = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   advance,
   input  bcd_t [NUM_DIGITS-1:0]  digits,
   output seg_t                   seg_lines,
   output logic [NUM_DIGITS-1:0]  dig_sel_n
);
   localparam int PW = (NUM_DIGITS > 2) ? $clog2(NUM_DIGITS) : 1;
   localparam logic [PW-1:0] LAST_POS = PW'(NUM_DIGITS - 1);

   logic [PW-1:0] pos;
   seg_t          pattern;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos <= '0;
      end else if (advance) begin
         pos <= (pos == LAST_POS) ? '0 : pos + 1'b1;
      end
   end

   assign dig_sel_n = ~(NUM_DIGITS'(1) << pos);
   assign pattern   = seg_pattern(digits[pos]);

   if (SEG_ACTIVE_LOW) begin : g_seg_low
      assign seg_lines = ~pattern;
   end else begin : g_seg_high
      assign seg_lines = pattern;
   end
endmodule

// File: rtl/msec_scan_display.sv
module msec_scan_display
   import msd_pkg::*;
#(
   parameter int NUM_DIGITS     = 4,
   parameter int TICK_DIV       = 100000,
   parameter int SCAN_DIV       = 100000,
   parameter bit SEG_ACTIVE_LOW = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  run,
   output logic [SEG_W-1:0]      seg_lines,
   output logic [NUM_DIGITS-1:0] dig_sel_n
);
   if (NUM_DIGITS < 1 || NUM_DIGITS > 8) begin : g_bad_digits
      $error("msec_scan_display: NUM_DIGITS must be 1..8");
   end

   logic                   ms_tick;
   logic                   scan_tick;
   bcd_t [NUM_DIGITS-1:0]  digits;

   msd_tick_gen #(.DIV(TICK_DIV)) u_ms_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (run),
      .tick  (ms_tick)
   );

   msd_tick_gen #(.DIV(SCAN_DIV)) u_scan_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (1'b1),
      .tick  (scan_tick)
   );

   msd_decade_chain #(.NUM_DIGITS(NUM_DIGITS)) u_chain (
      .clk    (clk),
      .rst_n  (rst_n),
      .step   (ms_tick),
      .digits (digits)
   );

   msd_scan_mux #(
      .NUM_DIGITS     (NUM_DIGITS),
      .SEG_ACTIVE_LOW (SEG_ACTIVE_LOW)
   ) u_scan (
      .clk       (clk),
      .rst_n     (rst_n),
      .advance   (scan_tick),
      .digits    (digits),
      .seg_lines (seg_lines),
      .dig_sel_n (dig_sel_n)
   );
endmodule

module msec_scan_display_chk
   import msd_pkg::*;
#(
   parameter int NUM_DIGITS = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  run,
   input logic                  ms_tick,
   input bcd_t [NUM_DIGITS-1:0] digits,
   input logic [NUM_DIGITS-1:0] dig_sel_n
);
   // R6
   sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(~dig_sel_n));

   if (NUM_DIGITS > 1) begin : g_rot
      // R5
      scan_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (dig_sel_n != $past(dig_sel_n)) |->
         (dig_sel_n == {$past(dig_sel_n[NUM_DIGITS-2:0]), $past(dig_sel_n[NUM_DIGITS-1])}));
   end

   for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_range
      // R4
      digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
         digits[i] <= 4'd9);
   end

   // R2
   no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ms_tick |=> $stable(digits));

   // R3
   stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(digits));

   // R4
   units_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ms_tick |=> digits[0] == (($past(digits[0]) == 4'd9) ? 4'd0 : $past(digits[0]) + 4'd1));
endmodule

bind msec_scan_display msec_scan_display_chk #(.NUM_DIGITS(NUM_DIGITS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .run       (run),
   .ms_tick   (ms_tick),
   .digits    (digits),
   .dig_sel_n (dig_sel_n)
);

// File: tb/tb_msec_scan_display.sv
`timescale 1ns/1ps
module tb_msec_scan_display;
   localparam int ND  = 4;
   localparam int TD  = 4;
   localparam int SD  = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          run = 1'b0;
   logic [6:0]    seg_lines;
   logic [ND-1:0] dig_sel_n;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   msec_scan_display #(
      .NUM_DIGITS(ND), .TICK_DIV(TD), .SCAN_DIV(SD), .SEG_ACTIVE_LOW(1'b1)
   ) dut (
      .clk(clk), .rst_n(rst_n), .run(run),
      .seg_lines(seg_lines), .dig_sel_n(dig_sel_n)
   );

   // active-low patterns, bit 0 = a ... bit 6 = g
   function automatic logic [6:0] enc(input int d);
      case (d)
         0: return 7'h40;  1: return 7'h79;  2: return 7'h24;  3: return 7'h30;
         4: return 7'h19;  5: return 7'h12;  6: return 7'h02;  7: return 7'h78;
         8: return 7'h00;  9: return 7'h10;
         default: return 7'h7F;
      endcase
   endfunction

   function automatic int dec(input logic [6:0] s);
      for (int d = 0; d < 10; d++) if (enc(d) == s) return d;
      return -1;
   endfunction

   task automatic check(input string req, input int got, input int exp);
      tests++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   // ---------------- reference model and scoreboard ----------------
   int m_pre, m_cnt, m_sc, m_sp;
   logic [ND+6:0] exp_q[$];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_pre <= 0; m_cnt <= 0; m_sc <= 0; m_sp <= 0;
      end else begin
         if (run) begin
            if (m_pre == TD-1) begin
               m_pre <= 0;
               m_cnt <= (m_cnt + 1) % 10000;
            end else m_pre <= m_pre + 1;
         end
         if (m_sc == SD-1) begin
            m_sc <= 0;
            m_sp <= (m_sp + 1) % ND;
         end else m_sc <= m_sc + 1;
      end
   end

   function automatic int digit_of(input int v, input int k);
      for (int i = 0; i < k; i++) v = v / 10;
      return v % 10;
   endfunction

   task automatic push_expect();
      logic [ND-1:0] s;
      s = ~(ND'(1) << m_sp);
      exp_q.push_back({s, enc(digit_of(m_cnt, m_sp))});
   endtask

   always @(negedge clk) if (!done) push_expect();

   always @(negedge clk) begin
      logic [ND+6:0] e;
      #1;
      if (!done && exp_q.size() > 0) begin
         e = exp_q.pop_front();
         tests++;
         if ({dig_sel_n, seg_lines} !== e) begin
            fails++;
            $display("FAIL R7 scoreboard: got sel=%b seg=%h expected sel=%b seg=%h",
                     dig_sel_n, seg_lines, e[ND+6:7], e[6:0]);
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic run_for(input int n);
      run = 1'b1;
      repeat (n) @(negedge clk);
      run = 1'b0;
   endtask

   task automatic read_display(output int value);
      int dg[ND];
      for (int k = 0; k < ND; k++) dg[k] = -1;
      repeat (ND*SD) begin
         @(negedge clk); #1;
         for (int k = 0; k < ND; k++) if (!dig_sel_n[k]) dg[k] = dec(seg_lines);
      end
      value = 0;
      for (int k = ND-1; k >= 0; k--) value = value*10 + ((dg[k] < 0) ? 99 : dg[k]);
   endtask

   // ---------------- scenarios ----------------
   initial begin
      int v, n;
      logic [ND-1:0] prev;
      repeat (3) @(negedge clk);
      #1;
      // R1: state during reset
      check("R1 sel in reset", dig_sel_n, 4'b1110);
      check("R1 seg in reset", seg_lines, enc(0));
      @(negedge clk); rst_n = 1'b1;

      // R5: scan spacing and order, R6 one-hot
      prev = dig_sel_n;
      for (int t = 0; t < 5; t++) begin
         n = 0;
         do begin @(negedge clk); #1; n++; end while (dig_sel_n == prev && n < 50);
         check("R5 scan interval", n, SD);
         check("R5 scan order", dig_sel_n, {prev[ND-2:0], prev[ND-1]});
         check("R6 one-hot", $countones(~dig_sel_n), 1);
         prev = dig_sel_n;
      end
      @(negedge clk);

      // R2: 7 steps
      run_for(7*TD);
      read_display(v);
      check("R2 count after 7 ms", v, 7);
      // R3: partial phase, stop, then resume
      run_for(2);
      read_display(v);
      check("R3 partial period no step", v, 7);
      repeat (40) @(negedge clk);
      read_display(v);
      check("R3 held while stopped", v, 7);
      run_for(TD-2);
      read_display(v);
      check("R3 phase kept across stop", v, 8);

      // R4/R8: carry into tens
      run_for(2*TD);
      read_display(v);
      check("R4 carry 9->10", v, 10);
      run_for(85*TD);
      read_display(v);
      check("R8 digit weights 95", v, 95);
      run_for(9904*TD);
      read_display(v);
      check("R8 full count 9999", v, 9999);
      run_for(TD);
      read_display(v);
      check("R4 wrap to 0000", v, 0);
      run_for(3*TD);

      // R1: asynchronous reset mid-run
      run = 1'b1;
      repeat (5) @(negedge clk);
      #1 rst_n = 1'b0;
      #0.5;
      check("R1 async sel", dig_sel_n, 4'b1110);
      check("R1 async seg", seg_lines, enc(0));
      run = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      read_display(v);
      check("R1 count cleared", v, 0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         tests++; fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule